// File: doc/BRIEF.md
# Selectable-Ratio Sample Output Demultiplexer

The block takes one converter sample on every rising clock edge and presents it on two output ports, a primary and an auxiliary, together with a data-ready strobe. A rate select input picks between two output modes. In full-rate mode every sample reaches the primary port at the sample rate, and the auxiliary port mirrors the same stream one clock later. In half-rate mode two consecutive samples leave together every second clock: the older one on the auxiliary port, the newer one on the primary port.

Every output is driven as a true/complement pair. Deasserting the auxiliary enable parks both lines of the auxiliary pair at all-ones, which is the level a powered-down differential driver pulls to. The primary port is not affected. Half-cycle latencies of a real converter are rounded up to whole register stages. The depth from `sample_in` to the primary port is the parameter `PRI_LAT` (default 8, minimum 2). The auxiliary path is one stage deeper.

The sample stream has no valid/ready handshake. The source delivers a sample every clock and cannot be stalled, and the outputs cannot apply back-pressure, so only the data-ready strobe qualifies the output. The reset is synchronous and active-low.

Top module: `sample_demux`

## Requirements
- R1: While `rst_n` is low at a clock edge, the edge clears the primary and auxiliary data to 0 and drives `rdy_p` low.
- R2: In full-rate mode, the sample on `sample_in` at edge k appears on `pri_p` after edge k+PRI_LAT-1, so it passes through PRI_LAT register stages.
- R3: In full-rate mode, after each edge the auxiliary data equals the value the primary port held before that edge, so it lags the primary port by one clock.
- R4: In full-rate mode, `rdy_p` inverts on every edge once data reaches the output stage.
- R5: In half-rate mode, the two ports update together every second clock. The auxiliary port then holds the older sample of a pair and the primary port holds the newer sample. Both ports hold steady on the other edges.
- R6: In half-rate mode, `rdy_p` goes to 1 on the edge that updates a pair and to 0 on the edge after it, so its rising edge marks new data.
- R7: The first sample captured after reset is the older half of a pair, and pairs follow back to back from there.
- R8: The rate select is sampled only with the older sample of each pair, and the newer sample keeps that choice. A pair is therefore never split across modes, whatever `half_sel` does in between.
- R9: When `aux_en` is 0, `aux_p` and `aux_n` are both all-ones. This has no effect on the primary port or on the strobe.
- R10: `pri_n` is the bitwise inverse of `pri_p` and `rdy_n` is the inverse of `rdy_p` at all times. While `aux_en` is 1, `aux_n` is the inverse of `aux_p`.
- R11: After reset, until the first captured sample reaches the output stage, the data ports stay 0 and `rdy_p` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_sel | input | 1 | Rate select: 0 full-rate, 1 half-rate |
| aux_en | input | 1 | Auxiliary port enable |
| sample_in | input | SAMPLE_W | Converter sample, one per clock |
| pri_p | output | SAMPLE_W | Primary port, true |
| pri_n | output | SAMPLE_W | Primary port, complement |
| aux_p | output | SAMPLE_W | Auxiliary port, true |
| aux_n | output | SAMPLE_W | Auxiliary port, complement |
| rdy_p | output | 1 | Data-ready strobe, true |
| rdy_n | output | 1 | Data-ready strobe, complement |

## Verification
On every cycle the assertions check the following:
- the reset clear;
- the strobe toggling in full-rate mode;
- the strobe's high/low pattern in half-rate mode;
- that the ports hold still on the non-update edge of a pair;
- the one-clock mirror of primary onto auxiliary;
- the complement pairs and the parked auxiliary lines.

Which sample value lands on which port after exactly how many clocks can be shown only by the bench scenarios, which compare against a per-sample model. The same holds for the alignment of pairs after a reset and for pairs staying whole while the rate select changes at random.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  typedef enum logic {
    RATE_FULL = 1'b0,
    RATE_HALF = 1'b1
  } rate_e;

  // Side information carried alongside each sample through the pipe
  typedef struct packed {
    logic  vld;   // slot carries a real sample (0 = reset bubble)
    logic  late;  // newer sample of a pair
    rate_e rate;  // mode chosen at the start of this sample's pair
  } slot_tag_t;
endpackage

// File: rtl/sdx_pair_tagger.sv
module sdx_pair_tagger
  import sdx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      half_sel,
  output slot_tag_t tag_o
);
  logic  phase_q;
  rate_e held_q;

  // Phase 0 marks the older sample of a pair; the rate is latched there
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      held_q  <= RATE_FULL;
    end else begin
      phase_q <= ~phase_q;
      if (!phase_q) held_q <= rate_e'(half_sel);
    end
  end

  always_comb begin
    tag_o.vld  = 1'b1;
    tag_o.late = phase_q;
    tag_o.rate = phase_q ? held_q : rate_e'(half_sel);
  end
endmodule

// File: rtl/sdx_delay_line.sv
module sdx_delay_line
  import sdx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  slot_tag_t         tag_i,
  output logic [DATA_W-1:0] tap_data_o,
  output slot_tag_t         tap_tag_o,
  output logic [DATA_W-1:0] last_data_o
);
  localparam int unsigned TAP = DEPTH - 2;
  localparam int unsigned LAST = DEPTH - 1;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    logic [DATA_W-1:0] d_q;
    slot_tag_t         t_q;
    logic [DATA_W-1:0] d_src;
    slot_tag_t         t_src;

    if (i == 0) begin : g_head
      assign d_src = data_i;
      assign t_src = tag_i;
    end else begin : g_body
      assign d_src = g_stg[i-1].d_q;
      assign t_src = g_stg[i-1].t_q;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        d_q <= '0;
        t_q <= '0;
      end else begin
        d_q <= d_src;
        t_q <= t_src;
      end
    end
  end

  assign tap_data_o  = g_stg[TAP].d_q;
  assign tap_tag_o   = g_stg[TAP].t_q;
  assign last_data_o = g_stg[LAST].d_q;
endmodule

// File: rtl/sdx_port_regs.sv
module sdx_port_regs
  import sdx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] newer_i,
  input  slot_tag_t         newer_tag_i,
  input  logic [DATA_W-1:0] older_i,
  output logic [DATA_W-1:0] pri_q,
  output logic [DATA_W-1:0] aux_q,
  output logic              rdy_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_q <= '0;
      aux_q <= '0;
      rdy_q <= 1'b0;
    end else if (newer_tag_i.vld) begin
      if (newer_tag_i.rate == RATE_FULL) begin
        pri_q <= newer_i;
        aux_q <= older_i;
        rdy_q <= ~rdy_q;
      end else if (newer_tag_i.late) begin
        pri_q <= newer_i;
        aux_q <= older_i;
        rdy_q <= 1'b1;
      end else begin
        rdy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdx_line_drive.sv
module sdx_line_drive #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              aux_en,
  input  logic [DATA_W-1:0] pri_q,
  input  logic [DATA_W-1:0] aux_q,
  input  logic              rdy_q,
  output logic [DATA_W-1:0] pri_p,
  output logic [DATA_W-1:0] pri_n,
  output logic [DATA_W-1:0] aux_p,
  output logic [DATA_W-1:0] aux_n,
  output logic              rdy_p,
  output logic              rdy_n
);
  // A parked differential driver pulls both legs high
  localparam logic [DATA_W-1:0] PARKED = '1;

  always_comb begin
    pri_p = pri_q;
    pri_n = ~pri_q;
    rdy_p = rdy_q;
    rdy_n = ~rdy_q;
    aux_p = aux_en ? aux_q  : PARKED;
    aux_n = aux_en ? ~aux_q : PARKED;
  end
endmodule

// File: rtl/sample_demux.sv
module sample_demux
  import sdx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned PRI_LAT  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                half_sel,
  input  logic                aux_en,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic [SAMPLE_W-1:0] pri_p,
  output logic [SAMPLE_W-1:0] pri_n,
  output logic [SAMPLE_W-1:0] aux_p,
  output logic [SAMPLE_W-1:0] aux_n,
  output logic                rdy_p,
  output logic                rdy_n
);
  localparam int unsigned AUX_LAT   = PRI_LAT + 1;
  // The output register is the last stage of each path
  localparam int unsigned PIPE_DEPTH = AUX_LAT - 1;

  slot_tag_t           in_tag;
  slot_tag_t           stage_tag;
  logic [SAMPLE_W-1:0] stage_data;
  logic [SAMPLE_W-1:0] prior_data;
  logic [SAMPLE_W-1:0] pri_q;
  logic [SAMPLE_W-1:0] aux_q;
  logic                rdy_q;

  sdx_pair_tagger u_tagger (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_sel (half_sel),
    .tag_o    (in_tag)
  );

  sdx_delay_line #(
    .DATA_W (SAMPLE_W),
    .DEPTH  (PIPE_DEPTH)
  ) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_i      (sample_in),
    .tag_i       (in_tag),
    .tap_data_o  (stage_data),
    .tap_tag_o   (stage_tag),
    .last_data_o (prior_data)
  );

  sdx_port_regs #(
    .DATA_W (SAMPLE_W)
  ) u_ports (
    .clk         (clk),
    .rst_n       (rst_n),
    .newer_i     (stage_data),
    .newer_tag_i (stage_tag),
    .older_i     (prior_data),
    .pri_q       (pri_q),
    .aux_q       (aux_q),
    .rdy_q       (rdy_q)
  );

  sdx_line_drive #(
    .DATA_W (SAMPLE_W)
  ) u_drive (
    .aux_en (aux_en),
    .pri_q  (pri_q),
    .aux_q  (aux_q),
    .rdy_q  (rdy_q),
    .pri_p  (pri_p),
    .pri_n  (pri_n),
    .aux_p  (aux_p),
    .aux_n  (aux_n),
    .rdy_p  (rdy_p),
    .rdy_n  (rdy_n)
  );
endmodule

// File: rtl/sample_demux_chk.sv
module sample_demux_chk
  import sdx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         aux_en,
  input slot_tag_t    stg_tag,
  input logic [W-1:0] pri_q,
  input logic [W-1:0] aux_q,
  input logic         rdy_q,
  input logic [W-1:0] pri_p,
  input logic [W-1:0] pri_n,
  input logic [W-1:0] aux_p,
  input logic [W-1:0] aux_n,
  input logic         rdy_p,
  input logic         rdy_n
);
  logic full_step;
  logic half_early;
  logic half_late;

  assign full_step  = stg_tag.vld && (stg_tag.rate == RATE_FULL);
  assign half_early = stg_tag.vld && (stg_tag.rate == RATE_HALF) && !stg_tag.late;
  assign half_late  = stg_tag.vld && (stg_tag.rate == RATE_HALF) && stg_tag.late;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pri_p == '0 && aux_q == '0 && !rdy_p));

  // R3
  aux_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_step && $past(full_step)) |=> (aux_q == $past(pri_q)));

  // R4
  full_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_step |=> (rdy_q != $past(rdy_q)));

  // R5
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_early |=> ($stable(pri_q) && $stable(aux_q) && !rdy_q));

  // R6
  pair_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_late |=> rdy_q);

  // R11
  bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stg_tag.vld |=> ($stable(pri_q) && $stable(rdy_q)));

  // R9
  aux_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_en |-> (aux_p == '1 && aux_n == '1));

  // R10
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_n == ~pri_p) && (rdy_n == !rdy_p) && (!aux_en || aux_n == ~aux_p));
endmodule

bind sample_demux sample_demux_chk #(.W(SAMPLE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .aux_en  (aux_en),
  .stg_tag (stage_tag),
  .pri_q   (pri_q),
  .aux_q   (aux_q),
  .rdy_q   (rdy_q),
  .pri_p   (pri_p),
  .pri_n   (pri_n),
  .aux_p   (aux_p),
  .aux_n   (aux_n),
  .rdy_p   (rdy_p),
  .rdy_n   (rdy_n)
);

// File: tb/sample_demux_test.sv
`timescale 1ns/1ps
module sample_demux_test;
  localparam int W   = 8;
  localparam int LAT = 8;
  localparam int MAXS = 4096;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         half_sel = 1'b0;
  logic         aux_en = 1'b1;
  logic [W-1:0] sample_in = '0;
  logic [W-1:0] pri_p, pri_n, aux_p, aux_n;
  logic         rdy_p, rdy_n;

  always #4 clk = ~clk;

  sample_demux #(.SAMPLE_W(W), .PRI_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .half_sel(half_sel), .aux_en(aux_en),
    .sample_in(sample_in), .pri_p(pri_p), .pri_n(pri_n),
    .aux_p(aux_p), .aux_n(aux_n), .rdy_p(rdy_p), .rdy_n(rdy_n)
  );

  int n_run = 0;
  int n_bad = 0;

  // Reference model, indexed by sample number since the last reset
  logic [W-1:0] m_smp [MAXS];
  logic         m_md  [MAXS];
  int           m_k = 0;
  logic [W-1:0] e_pri = '0;
  logic [W-1:0] e_aux = '0;
  logic         e_rdy = 1'b0;
  string        t_pri = "R1";
  string        t_aux = "R1";
  string        t_rdy = "R1";
  bit           mixed = 0;
  bit           pair_watch = 0;
  logic [W-1:0] pair_old, pair_new;

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(logic r, logic m, logic [W-1:0] s);
    int j;
    if (!r) begin
      m_k = 0; e_pri = '0; e_aux = '0; e_rdy = 1'b0;
      t_pri = "R1"; t_aux = "R1"; t_rdy = "R1";
      return;
    end
    if (m_k < MAXS) begin
      m_smp[m_k] = s;
      m_md[m_k]  = (m_k % 2 == 0) ? m : m_md[m_k-1];
    end
    m_k++;
    j = m_k - LAT;
    if (j < 0 || j >= MAXS) begin
      t_pri = "R11"; t_aux = "R11"; t_rdy = "R11";
      return;
    end
    if (!m_md[j]) begin
      e_pri = m_smp[j];
      e_aux = (j > 0) ? m_smp[j-1] : '0;
      e_rdy = ~e_rdy;
      t_pri = "R2"; t_aux = "R3"; t_rdy = "R4";
    end else begin
      if (j % 2 == 1) begin
        e_pri = m_smp[j];
        e_aux = m_smp[j-1];
        e_rdy = 1'b1;
      end else begin
        e_rdy = 1'b0;
      end
      t_pri = "R5"; t_aux = "R5"; t_rdy = "R6";
    end
    if (mixed) begin
      t_pri = "R8"; t_aux = "R8";
    end
  endtask

  task automatic step(logic r, logic m, logic a, logic [W-1:0] s);
    rst_n = r; half_sel = m; aux_en = a; sample_in = s;
    @(posedge clk);
    @(negedge clk);
    model_edge(r, m, s);
    check(t_pri, pri_p, e_pri);
    check("R10", pri_n, ~e_pri);
    check(t_rdy, {7'd0, rdy_p}, {7'd0, e_rdy});
    check("R10", {7'd0, rdy_n}, {7'd0, ~e_rdy});
    if (a) begin
      check(t_aux, aux_p, e_aux);
      check("R10", aux_n, ~e_aux);
    end else begin
      check("R9", aux_p, 8'hFF);
      check("R9", aux_n, 8'hFF);
    end
    if (pair_watch && rdy_p) begin
      pair_watch = 0;
      check("R7", aux_p, pair_old);
      check("R7", pri_p, pair_new);
    end
  endtask

  function automatic logic [W-1:0] rnd8();
    return W'($urandom());
  endfunction

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    for (int i = 0; i < 4; i++) step(1'b0, 1'(i), 1'b1, rnd8());
    // R2 R3 R4 R11: full-rate stream
    for (int i = 0; i < 150; i++) step(1'b1, 1'b0, 1'b1, rnd8());
    // R9: auxiliary enable toggling
    for (int i = 0; i < 100; i++) step(1'b1, 1'b0, ($urandom() % 4) != 0, rnd8());
    // R7: directed pair alignment after reset
    step(1'b0, 1'b1, 1'b1, 8'h00);
    step(1'b0, 1'b1, 1'b1, 8'h00);
    pair_old = 8'hA5; pair_new = 8'h3C; pair_watch = 1;
    step(1'b1, 1'b1, 1'b1, 8'hA5);
    step(1'b1, 1'b1, 1'b1, 8'h3C);
    // R5 R6: half-rate stream
    for (int i = 0; i < 200; i++) step(1'b1, 1'b1, 1'b1, rnd8());
    for (int i = 0; i < 100; i++) step(1'b1, 1'b1, ($urandom() % 3) != 0, rnd8());
    // R8: rate select changing at random inside pairs
    mixed = 1;
    for (int i = 0; i < 600; i++) step(1'b1, 1'($urandom()), 1'b1, rnd8());
    mixed = 0;
    // R7: reset in the middle of a pair
    step(1'b0, 1'b1, 1'b1, 8'h11);
    pair_old = 8'h5A; pair_new = 8'hC3; pair_watch = 1;
    step(1'b1, 1'b1, 1'b1, 8'h5A);
    step(1'b1, 1'b1, 1'b1, 8'hC3);
    for (int i = 0; i < 100; i++) step(1'b1, 1'b1, 1'b1, rnd8());
    // R5: extreme codes alternating
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b1, (i % 2 != 0) ? 8'hFF : 8'h00);
    // R2: back to full rate with extreme codes
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b1, (i % 3 == 0) ? 8'hFF : 8'h00);
    if (pair_watch) begin
      n_run++; n_bad++;
      $display("FAIL R7 actual=no pair strobe expected=pair strobe");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule